// File: doc/BRIEF.md
# Dual-Context Serial Configuration Loader

This block loads configuration for a programmable fabric. A bitstream arrives one bit per clock on a serial line and collects in a shift register. A write strobe copies the shift register into one of two stored configuration slots. An apply strobe copies a stored slot onto a registered parallel output that drives the fabric.

Until the first apply after reset, the parallel output is held at all zeros, which is the all-disabled state, and the valid flag stays low. Whatever the slot memory held at power-up therefore never reaches the fabric. Because two complete configurations are stored, the fabric can switch from one to the other in one cycle, with no new shifting.

Top module: `cfg_ctx_loader`

## Requirements
- R1: While `rst` is high at a clock edge, `cfg_out` becomes all zeros and `cfg_valid` becomes 0 after that edge, and the shift register is cleared.
- R2: Each cycle with `shift_en` high moves the shift register up by one bit and places `ser_in` in bit 0. The first bit of a `CFG_W`-bit stream therefore lands in bit `CFG_W-1`.
- R3: A cycle with `commit` high stores the shift register, as it was before that edge, into slot `ctx_sel` (0 or 1). A later apply of that slot shows the stored word.
- R4: Until the first `apply` after reset, `cfg_out` stays zero and `cfg_valid` stays 0, whatever happens on `shift_en`, `ser_in` and `commit`.
- R5: A cycle with `apply` high loads `cfg_out` from slot `ctx_sel`, visible one cycle later, and sets `cfg_valid` to 1.
- R6: Once `cfg_valid` is 1, it stays 1 until reset.
- R7: When `commit` and `apply` are high in the same cycle, `cfg_out` takes the shift register contents that are being written.
- R8: `cfg_out` changes only on an apply or a reset. Shifting and committing alone leave it unchanged.
- R9: Applying slot 0 and slot 1 in turn switches `cfg_out` between the two stored words with no reshifting.
- R10: When `shift_en` and `commit` are high in the same cycle, the slot receives the pre-shift contents and the shift register still advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial bitstream data |
| shift_en | input | 1 | Shift one bit in this cycle |
| commit | input | 1 | Write the shift register into slot `ctx_sel` |
| apply | input | 1 | Load the output from slot `ctx_sel` |
| ctx_sel | input | 1 | Slot index for commit and apply |
| cfg_out | output | CFG_W | Active configuration word for the fabric |
| cfg_valid | output | 1 | High once a configuration has been applied |

## Verification
Two pairs of functions can fall in the same cycle: commit with apply, and shift with commit. The bench raises commit and apply on one edge for a slot that holds an older word, and expects the output to show the freshly shifted word (R7). It then shifts the last bit of a stream on the same edge as a commit, and expects a later apply to show the word without that last bit (R10). A reference model in the bench computes the expected word for every cycle, and a scoreboard compares it with the output.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  localparam int NUM_CTX = 2;
  localparam int CTX_IW  = 1;
  typedef logic [CTX_IW-1:0] ctx_idx_t;
endpackage

// File: rtl/cfg_shift_reg.sv
module cfg_shift_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         ser_in,
  output logic [W-1:0] sr_q
);
  always_ff @(posedge clk) begin
    if (rst)           sr_q <= '0;
    else if (shift_en) sr_q <= {sr_q[W-2:0], ser_in};
  end
endmodule

// File: rtl/cfg_ctx_mem.sv
module cfg_ctx_mem
  import cfg_loader_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         we,
  input  ctx_idx_t     addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata
);
  logic [W-1:0] slots [NUM_CTX];

  always_ff @(posedge clk) begin
    if (we) slots[addr] <= wdata;
  end

  assign rdata = slots[addr];
endmodule

// File: rtl/cfg_apply_stage.sv
module cfg_apply_stage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         apply,
  input  logic         bypass,
  input  logic [W-1:0] fresh_word,
  input  logic [W-1:0] stored_word,
  output logic [W-1:0] out_q,
  output logic         valid_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_q   <= '0;
      valid_q <= 1'b0;
    end else if (apply) begin
      out_q   <= bypass ? fresh_word : stored_word;
      valid_q <= 1'b1;
    end
  end
endmodule

// File: rtl/cfg_ctx_loader.sv
module cfg_ctx_loader
  import cfg_loader_pkg::*;
#(
  parameter int CFG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_in,
  input  logic             shift_en,
  input  logic             commit,
  input  logic             apply,
  input  logic             ctx_sel,
  output logic [CFG_W-1:0] cfg_out,
  output logic             cfg_valid
);
  logic [CFG_W-1:0] shift_q;
  logic [CFG_W-1:0] slot_rd;
  ctx_idx_t         slot_idx;

  assign slot_idx = ctx_idx_t'(ctx_sel);

  cfg_shift_reg #(.W(CFG_W)) u_shift (
    .clk(clk), .rst(rst), .shift_en(shift_en), .ser_in(ser_in), .sr_q(shift_q)
  );

  cfg_ctx_mem #(.W(CFG_W)) u_mem (
    .clk(clk), .we(commit), .addr(slot_idx), .wdata(shift_q), .rdata(slot_rd)
  );

  cfg_apply_stage #(.W(CFG_W)) u_apply (
    .clk(clk), .rst(rst), .apply(apply), .bypass(commit),
    .fresh_word(shift_q), .stored_word(slot_rd),
    .out_q(cfg_out), .valid_q(cfg_valid)
  );
endmodule

// File: rtl/cfg_ctx_loader_chk.sv
module cfg_ctx_loader_chk #(
  parameter int CFG_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             commit,
  input logic             apply,
  input logic [CFG_W-1:0] shift_q,
  input logic [CFG_W-1:0] cfg_out,
  input logic             cfg_valid
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (cfg_out == '0 && !cfg_valid));

  p_safe_until_apply_r4: assert property (@(posedge clk) disable iff (rst)
    !cfg_valid |-> cfg_out == '0);

  p_apply_sets_valid_r5: assert property (@(posedge clk) disable iff (rst)
    apply |=> cfg_valid);

  p_valid_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    cfg_valid |=> cfg_valid);

  p_bypass_fresh_r7: assert property (@(posedge clk) disable iff (rst)
    (apply && commit) |=> cfg_out == $past(shift_q));

  p_hold_no_apply_r8: assert property (@(posedge clk) disable iff (rst)
    !apply |=> $stable(cfg_out));
endmodule

bind cfg_ctx_loader cfg_ctx_loader_chk #(.CFG_W(CFG_W)) u_chk (
  .clk(clk), .rst(rst), .commit(commit), .apply(apply),
  .shift_q(shift_q), .cfg_out(cfg_out), .cfg_valid(cfg_valid)
);

// File: tb/sim_cfg_ctx_loader.sv
`timescale 1ns/1ps
module sim_cfg_ctx_loader;
  localparam int W = 32;

  typedef struct {
    int          cyc;
    logic [W-1:0] data;
    logic        valid;
    string       req;
  } exp_t;

  logic clk = 0, rst = 1, ser_in = 0, shift_en = 0, commit = 0, apply = 0, ctx_sel = 0;
  logic [W-1:0] cfg_out;
  logic cfg_valid;

  int cyc = 0, checks = 0, failures = 0;
  bit done = 0;
  exp_t q[$];
  string cur_req = "R1";

  logic [W-1:0] m_sr = '0, m_out = '0;
  logic [W-1:0] m_mem [2];
  logic m_valid = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cfg_ctx_loader #(.CFG_W(W)) u0 (
    .clk(clk), .rst(rst), .ser_in(ser_in), .shift_en(shift_en), .commit(commit),
    .apply(apply), .ctx_sel(ctx_sel), .cfg_out(cfg_out), .cfg_valid(cfg_valid)
  );

  // driver: drives one cycle, advances the model, queues the expected result
  task automatic step(input logic r, input logic sh, input logic b,
                      input logic wr, input logic rd, input logic c);
    @(negedge clk);
    rst = r; shift_en = sh; ser_in = b; commit = wr; apply = rd; ctx_sel = c;
    if (r) begin
      m_out = '0; m_valid = 0; m_sr = '0;
    end else begin
      if (rd) begin
        m_out = wr ? m_sr : m_mem[c];
        m_valid = 1;
      end
      if (wr) m_mem[c] = m_sr;
      if (sh) m_sr = {m_sr[W-2:0], b};
    end
    q.push_back('{cyc + 1, m_out, m_valid, cur_req});
  endtask

  task automatic shift_word(input logic [W-1:0] w);
    for (int i = W - 1; i >= 0; i--) step(0, 1, w[i], 0, 0, 0);
  endtask

  // monitor: compares away from the active edge
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc == cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (cfg_out !== e.data || cfg_valid !== e.valid) begin
        failures++;
        $display("FAIL %s: cfg_out=%h valid=%b expected cfg_out=%h valid=%b",
                 e.req, cfg_out, cfg_valid, e.data, e.valid);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cur_req = "R1"; step(1, 0, 0, 0, 0, 0); step(1, 0, 0, 0, 0, 0);
    cur_req = "R4"; shift_word(32'hA5C3_0F1E);
    cur_req = "R3"; step(0, 0, 0, 1, 0, 0);
    cur_req = "R4"; shift_word(32'h1234_5678); step(0, 0, 0, 1, 0, 1);
    step(0, 0, 0, 0, 0, 0);
    cur_req = "R5"; step(0, 0, 0, 0, 1, 0);
    cur_req = "R9"; step(0, 0, 0, 0, 1, 1); step(0, 0, 0, 0, 1, 0); step(0, 0, 0, 0, 1, 1);
    cur_req = "R8"; shift_word(32'hDEAD_BEEF); step(0, 0, 0, 1, 0, 0);
    cur_req = "R7"; step(0, 0, 0, 1, 1, 1);
    cur_req = "R3"; step(0, 0, 0, 0, 1, 0); step(0, 0, 0, 0, 1, 1);
    cur_req = "R2"; shift_word(32'h8000_0000); step(0, 0, 0, 1, 1, 0);
    shift_word(32'h0000_0001); step(0, 0, 0, 1, 1, 0);
    cur_req = "R10";
    for (int i = W - 1; i >= 1; i--) step(0, 1, 1'b1, 0, 0, 0);
    step(0, 1, 1'b0, 1, 0, 1);
    step(0, 0, 0, 0, 1, 1);
    step(0, 0, 0, 1, 1, 0);
    cur_req = "R6"; repeat (5) step(0, 1, 1'b1, 0, 0, 0);
    cur_req = "R1"; step(1, 0, 0, 0, 0, 0);
    cur_req = "R4"; shift_word(32'h0F0F_00FF); step(0, 0, 0, 1, 0, 0); step(0, 0, 0, 0, 0, 1);
    cur_req = "R5"; step(0, 0, 0, 0, 1, 0);
    cur_req = "R6"; repeat (4) step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    while (q.size() > 0) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule